// File: doc/BRIEF.md
# Cluster Low-Power Coordinator

This block sits beside a group of cores that share a cache and a system power domain. Each core reports two levels: whether it is idle, and whether it votes for full power collapse. The coordinator filters both through a two-sample stability check, so a one-cycle change never reaches its decision logic. It then decides how deep the shared logic may sleep.

When every core is idle, the coordinator asks the shared cache to go into standby. Once the cache reports standby and every idle core also votes for collapse, it raises a shutdown request to an external resource manager. It holds that request until the manager acknowledges it. If a core withdraws before the acknowledge arrives, the request is replaced by a cancel, and the cancel is held until it too is acknowledged.

On any wake, the coordinator withdraws the cache standby request. It raises cluster-ready only after the cache reports that it has left standby and the manager's acknowledge has returned low. Cores therefore never resume into a sleeping cache.

Top module: `cluster_lpm_coord`

## Requirements
- R1: After reset, cluster_ready_o is 1 and cache_stby_req_o, rm_sd_req_o and rm_cancel_o are 0.
- R2: A core input takes effect only after it holds the same value at two consecutive rising edges. A value present at only one edge has no effect on any output.
- R3: cache_stby_req_o rises only when the filtered idle bits of all NCORES cores are 1. It rises one edge after that condition is first seen while the cluster is running, and cluster_ready_o falls at the same edge.
- R4: rm_sd_req_o rises only when every filtered idle bit and every filtered vote bit is 1 and cache_in_stby_i is 1. It stays at 1 until rm_ack_i is seen or a vote is withdrawn.
- R5: If any filtered idle or vote bit drops while the shutdown request is unacknowledged, rm_sd_req_o falls and rm_cancel_o rises at the same edge. rm_cancel_o stays at 1 until rm_ack_i is seen.
- R6: After an acknowledged shutdown, a dropped filtered idle or vote bit removes rm_sd_req_o and cache_stby_req_o without raising rm_cancel_o.
- R7: cluster_ready_o rises only after an edge at which cache_in_stby_i and rm_ack_i are both 0.
- R8: From cache standby, a single core leaving idle removes cache_stby_req_o at the next edge after its filtered bit drops.
- R9: If rm_ack_i and a withdrawal are seen at the same edge during an unacknowledged request, the acknowledge wins. No cancel is raised, and the withdrawal then leads to exit as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_idle_i | input | NCORES | Per-core idle level |
| core_pc_vote_i | input | NCORES | Per-core vote for full power collapse |
| cache_in_stby_i | input | 1 | Shared cache reports that it is in standby |
| rm_ack_i | input | 1 | Resource manager acknowledge for a request or a cancel |
| cache_stby_req_o | output | 1 | Request for shared cache standby |
| rm_sd_req_o | output | 1 | Subsystem shutdown request to the resource manager |
| rm_cancel_o | output | 1 | Cancel of an unacknowledged shutdown request |
| cluster_ready_o | output | 1 | Cores may run |

## Verification
On every cycle, the assertions check four relations. The stability filter only changes after two equal samples. Cache standby and shutdown requests only rise after the unanimity conditions held. A cancel is held until it is acknowledged. Cluster-ready only rises after the cache and the acknowledge are both low. Only the bench's scenarios show the full orderings: a glitch that has no effect, a partial-idle group that never reaches standby, and the three exit paths (plain wake, wake after acknowledge, wake before acknowledge). They also show the race in which the acknowledge and a withdrawal arrive at the same edge.

// File: rtl/cluster_lpm_pkg.sv
package cluster_lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_STBY   = 3'd1,
    ST_SDREQ  = 3'd2,
    ST_OFF    = 3'd3,
    ST_CANCEL = 3'd4,
    ST_EXIT   = 3'd5
  } lpm_state_e;
endpackage

// File: rtl/lpm_stable_filter.sv
module lpm_stable_filter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] smp_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q[i] <= 1'b0;
        q_o[i]   <= 1'b0;
      end else begin
        smp_q[i] <= d_i[i];
        if (d_i[i] == smp_q[i]) q_o[i] <= d_i[i];
      end
    end

    // R2: a filtered change needs the same raw value at two edges
    assert_two_sample_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[i] != $past(q_o[i])) |-> ($past(d_i[i]) == q_o[i] && $past(d_i[i], 2) == q_o[i]));
  end
endmodule

// File: rtl/lpm_vote_reduce.sv
module lpm_vote_reduce #(
  parameter int NCORES = 4
) (
  input  logic [NCORES-1:0] idle_i,
  input  logic [NCORES-1:0] vote_i,
  output logic              all_idle_o,
  output logic              all_pc_o
);
  logic [NCORES-1:0] pc_ok;

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    assign pc_ok[c] = idle_i[c] & vote_i[c];
  end

  assign all_idle_o = &idle_i;
  assign all_pc_o   = &pc_ok;
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
  import cluster_lpm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic all_idle_i,
  input  logic all_pc_i,
  input  logic cache_in_stby_i,
  input  logic rm_ack_i,
  output logic cache_stby_req_o,
  output logic rm_sd_req_o,
  output logic rm_cancel_o,
  output logic cluster_ready_o
);
  lpm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:    if (all_idle_i) st_d = ST_STBY;
      ST_STBY: begin
        if (!all_idle_i)                      st_d = ST_EXIT;
        else if (cache_in_stby_i && all_pc_i) st_d = ST_SDREQ;
      end
      ST_SDREQ: begin
        if (rm_ack_i)       st_d = ST_OFF;    // ack wins over a same-edge withdrawal
        else if (!all_pc_i) st_d = ST_CANCEL;
      end
      ST_OFF:    if (!all_pc_i) st_d = ST_EXIT;
      ST_CANCEL: if (rm_ack_i)  st_d = ST_EXIT;
      ST_EXIT:   if (!cache_in_stby_i && !rm_ack_i) st_d = ST_RUN;
      default:   st_d = ST_EXIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  always_comb begin
    cache_stby_req_o = 1'b0;
    rm_sd_req_o      = 1'b0;
    rm_cancel_o      = 1'b0;
    cluster_ready_o  = 1'b0;
    unique case (st_q)
      ST_RUN:    cluster_ready_o = 1'b1;
      ST_STBY:   cache_stby_req_o = 1'b1;
      ST_SDREQ, ST_OFF: begin
        cache_stby_req_o = 1'b1;
        rm_sd_req_o      = 1'b1;
      end
      ST_CANCEL: begin
        cache_stby_req_o = 1'b1;
        rm_cancel_o      = 1'b1;
      end
      default: ;
    endcase
  end

  assert_stby_unanimous_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cache_stby_req_o) |-> $past(all_idle_i));

  assert_sd_unanimous_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rm_sd_req_o) |-> ($past(all_pc_i) && $past(cache_in_stby_i)));

  assert_sd_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_sd_req_o && !rm_ack_i && all_pc_i) |=> rm_sd_req_o);

  assert_cancel_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_cancel_o && !rm_ack_i) |=> rm_cancel_o);

  assert_ready_after_cache_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cluster_ready_o) |-> (!$past(cache_in_stby_i) && !$past(rm_ack_i)));
endmodule

// File: rtl/cluster_lpm_coord.sv
module cluster_lpm_coord #(
  parameter int NCORES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCORES-1:0] core_idle_i,
  input  logic [NCORES-1:0] core_pc_vote_i,
  input  logic              cache_in_stby_i,
  input  logic              rm_ack_i,
  output logic              cache_stby_req_o,
  output logic              rm_sd_req_o,
  output logic              rm_cancel_o,
  output logic              cluster_ready_o
);
  localparam int FW = 2 * NCORES;

  logic [FW-1:0]     flt_q;
  logic [NCORES-1:0] idle_f, vote_f;
  logic              all_idle, all_pc;

  lpm_stable_filter #(.W(FW)) u_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({core_pc_vote_i, core_idle_i}),
    .q_o   (flt_q)
  );

  assign idle_f = flt_q[NCORES-1:0];
  assign vote_f = flt_q[FW-1:NCORES];

  lpm_vote_reduce #(.NCORES(NCORES)) u_red (
    .idle_i    (idle_f),
    .vote_i    (vote_f),
    .all_idle_o(all_idle),
    .all_pc_o  (all_pc)
  );

  lpm_seq_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .all_idle_i      (all_idle),
    .all_pc_i        (all_pc),
    .cache_in_stby_i (cache_in_stby_i),
    .rm_ack_i        (rm_ack_i),
    .cache_stby_req_o(cache_stby_req_o),
    .rm_sd_req_o     (rm_sd_req_o),
    .rm_cancel_o     (rm_cancel_o),
    .cluster_ready_o (cluster_ready_o)
  );

  assert_req_cancel_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rm_sd_req_o && rm_cancel_o));
endmodule

// File: tb/tb_cluster_lpm_coord.sv
module tb_cluster_lpm_coord;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] idle = '0, vote = '0;
  logic cache_in = 1'b0, ack = 1'b0;
  logic stby_o, sd_o, cancel_o, ready_o;

  always #2.5 clk = ~clk;

  cluster_lpm_coord #(.NCORES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .core_idle_i(idle), .core_pc_vote_i(vote),
    .cache_in_stby_i(cache_in), .rm_ack_i(ack),
    .cache_stby_req_o(stby_o), .rm_sd_req_o(sd_o),
    .rm_cancel_o(cancel_o), .cluster_ready_o(ready_o)
  );

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference: 0 run,1 standby,2 request,3 off,4 cancel,5 exit
  int m_st = 0;
  logic [N-1:0] m_si = '0, m_fi = '0, m_sv = '0, m_fv = '0;

  task automatic model_edge();
    bit ai, ap;
    ai = (m_fi == {N{1'b1}});
    ap = ai && (m_fv == {N{1'b1}});
    case (m_st)
      0: if (ai) m_st = 1;
      1: if (!ai) m_st = 5; else if (cache_in && ap) m_st = 2;
      2: if (ack) m_st = 3; else if (!ap) m_st = 4;
      3: if (!ap) m_st = 5;
      4: if (ack) m_st = 5;
      5: if (!cache_in && !ack) m_st = 0;
      default: m_st = 5;
    endcase
    for (int i = 0; i < N; i++) begin
      if (idle[i] == m_si[i]) m_fi[i] = idle[i];
      if (vote[i] == m_sv[i]) m_fv[i] = vote[i];
    end
    m_si = idle;
    m_sv = vote;
  endtask

  task automatic chk(string req, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, ready_o,  m_st == 0, "cluster_ready_o");
    chk(cur_req, stby_o,   m_st >= 1 && m_st <= 4, "cache_stby_req_o");
    chk(cur_req, sd_o,     m_st == 2 || m_st == 3, "rm_sd_req_o");
    chk(cur_req, cancel_o, m_st == 4, "rm_cancel_o");
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", ready_o, 1'b1, "ready in reset");
    chk("R1", stby_o, 1'b0, "stby in reset");
    chk("R1", sd_o, 1'b0, "sd in reset");
    chk("R1", cancel_o, 1'b0, "cancel in reset");
    rst_n = 1'b1;
    step(3);

    cur_req = "R2";   // one-edge glitch on all idle bits
    idle = '1; step(1); idle = '0; step(4);
    chk("R2", stby_o, 1'b0, "glitch stby");
    chk("R2", ready_o, 1'b1, "glitch ready");
    vote = '1; step(1); vote = '0; idle = '1; step(1); idle = '0; step(3);
    chk("R2", sd_o, 1'b0, "vote glitch sd");

    cur_req = "R3";   // partial idle never requests standby
    idle = 4'h7; step(5);
    chk("R3", stby_o, 1'b0, "partial idle stby");
    idle = 4'hF; step(4);
    chk("R3", stby_o, 1'b1, "all idle stby");
    chk("R3", ready_o, 1'b0, "all idle ready");

    cur_req = "R8";
    cache_in = 1'b1; step(2);
    idle = 4'hE; step(4);
    chk("R8", stby_o, 1'b0, "wake drops stby");
    cur_req = "R7";
    step(3);
    chk("R7", ready_o, 1'b0, "ready waits for cache");
    cache_in = 1'b0; step(1);
    chk("R7", ready_o, 1'b1, "ready after cache exit");

    cur_req = "R4";
    idle = 4'hF; vote = 4'hF; step(4);
    step(3);
    chk("R4", sd_o, 1'b0, "no sd before cache standby");
    cache_in = 1'b1; step(5);
    chk("R4", sd_o, 1'b1, "sd held without ack");
    ack = 1'b1; step(3);
    cur_req = "R6";
    chk("R6", sd_o, 1'b1, "sd held after ack");
    idle = 4'hE; vote = 4'hE; step(4);
    chk("R6", sd_o, 1'b0, "sd dropped on wake");
    chk("R6", cancel_o, 1'b0, "no cancel after ack");
    step(2);
    chk("R7", ready_o, 1'b0, "ready waits for ack low");
    ack = 1'b0; cache_in = 1'b0; step(1);
    chk("R7", ready_o, 1'b1, "ready after ack low");

    cur_req = "R5";
    idle = 4'hF; vote = 4'hF; cache_in = 1'b1; step(5);
    chk("R5", sd_o, 1'b1, "sd raised");
    idle = 4'hD; step(4);
    chk("R5", cancel_o, 1'b1, "cancel on early wake");
    chk("R5", sd_o, 1'b0, "sd dropped on cancel");
    step(3);
    chk("R5", cancel_o, 1'b1, "cancel held");
    ack = 1'b1; step(1);
    chk("R5", cancel_o, 1'b0, "cancel cleared by ack");
    chk("R5", ready_o, 1'b0, "no ready with ack high");
    ack = 1'b0; cache_in = 1'b0; step(1);
    chk("R5", ready_o, 1'b1, "ready after cancel");

    cur_req = "R9";
    idle = 4'hF; vote = 4'hF; cache_in = 1'b1; step(5);
    idle = 4'hB; step(2);
    ack = 1'b1; step(1);
    chk("R9", sd_o, 1'b1, "ack wins race");
    chk("R9", cancel_o, 1'b0, "no cancel in race");
    step(1);
    chk("R9", sd_o, 1'b0, "exit after race");
    ack = 1'b0; cache_in = 1'b0; step(2);
    chk("R9", ready_o, 1'b1, "ready after race");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule